// File: doc/BRIEF.md
# Occupancy-Balanced Thread Fetch Arbiter

This block decides, once per cycle, which hardware thread of a multithreaded core may use the single fetch slot. For each thread it keeps a saturating count of instructions that sit between fetch and issue. Fetch events raise the count and issue or squash events lower it. The grant goes to the qualifying thread with the smallest count, so that threads tend toward equal use of the shared front-end and queue resources.

A thread qualifies when it is active, not stalled (for example, waiting on an instruction cache miss), and below its fixed occupancy cap. The cap is the thread's static share of the partitioned structures. When counts are equal, a round-robin pointer picks the winner; the same pointer scheme that rotates the shared decode stage is used for this. The pointer moves to the thread after the winner, and it moves only on cycles that issue a grant. At most one thread is granted per cycle. A lone active thread receives every slot for which it qualifies.

The grant is combinational from the registered counts, the pointer and the current flags. Counts and the pointer change at the rising clock edge.

Top module: `occupancy_fetch_arbiter`

## Requirements
- R1: While reset is low, every count is zero and the round-robin pointer is at thread 0.
- R2: A thread's count rises by one on a cycle with only its increment pulse and falls by one on a cycle with only its decrement pulse. With both pulses or neither, the count is unchanged.
- R3: A count already at 2^CNT_W-1 stays there on an increment-only cycle. A count at zero stays zero on a decrement-only cycle.
- R4: A thread is eligible only if it is active, its stall flag is low, and its count is strictly less than its cap. A cap of zero means the thread is never granted.
- R5: The grant goes to an eligible thread whose count is the minimum among all eligible threads.
- R6: Among eligible threads that share the minimum count, the winner is the first one met when walking upward in index from the pointer, wrapping from the last thread to thread 0.
- R7: On a cycle with a grant to thread g, the pointer becomes g+1, or 0 when g is the last thread. On a cycle without a grant, the pointer is unchanged.
- R8: The grant has at most one bit set (bit i is thread i). It is all zeros exactly when no thread is eligible.
- R9: When only one thread is active, that thread is granted on every cycle in which it is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_inc | input | THREADS | Per-thread pulse: one instruction entered the front end |
| fetch_dec | input | THREADS | Per-thread pulse: one instruction issued or was squashed |
| thr_active | input | THREADS | Per-thread active flag |
| thr_stall | input | THREADS | Per-thread stall flag |
| thr_cap | input | THREADS*CNT_W | Per-thread occupancy cap; thread i uses bits [i*CNT_W +: CNT_W] |
| grant | output | THREADS | One-hot fetch grant, or zero |
| occupancy | output | THREADS*CNT_W | Per-thread current count, packed in the same way as thr_cap |

## Verification
The bench builds the block with THREADS=4 and CNT_W=3. With these values a count saturates at 7 after a few pulses, so both the ceiling and the floor of every counter are reached many times. Caps between 0 and 7 make cap-blocked and never-eligible threads common. Small counts also produce frequent ties, which exercises the wrap of the round-robin pointer. A per-cycle arithmetic model is compared against the grant and the counts, first in directed phases and then over a long pseudo-random stream of pulses, stall flags and active masks.

// File: rtl/occupancy_fetch_arbiter.sv
module occupancy_fetch_arbiter #(
  parameter int THREADS = 4,
  parameter int CNT_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [THREADS-1:0]       fetch_inc,
  input  logic [THREADS-1:0]       fetch_dec,
  input  logic [THREADS-1:0]       thr_active,
  input  logic [THREADS-1:0]       thr_stall,
  input  logic [THREADS*CNT_W-1:0] thr_cap,
  output logic [THREADS-1:0]       grant,
  output logic [THREADS*CNT_W-1:0] occupancy
);
  localparam int PTR_W = (THREADS > 1) ? $clog2(THREADS) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(THREADS - 1);

  logic [CNT_W-1:0] cnt_q [THREADS];
  logic [THREADS-1:0] elig;
  logic [PTR_W-1:0] rr_q, pick;
  logic [CNT_W-1:0] best;
  logic found;

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    assign elig[t] = thr_active[t] & ~thr_stall[t] & (cnt_q[t] < thr_cap[t*CNT_W +: CNT_W]);
    assign occupancy[t*CNT_W +: CNT_W] = cnt_q[t];

    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[t] <= '0;
      else begin
        case ({fetch_inc[t], fetch_dec[t]})
          2'b10: if (cnt_q[t] != CNT_MAX) cnt_q[t] <= cnt_q[t] + 1'b1;
          2'b01: if (cnt_q[t] != '0) cnt_q[t] <= cnt_q[t] - 1'b1;
          default: ;
        endcase
      end
    end

    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_inc[t] && !fetch_dec[t] && occupancy[t*CNT_W +: CNT_W] != CNT_MAX
      |=> occupancy[t*CNT_W +: CNT_W] == $past(occupancy[t*CNT_W +: CNT_W]) + 1'b1);
    p_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_inc[t] == fetch_dec[t] |=> $stable(occupancy[t*CNT_W +: CNT_W]));
    p_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_inc[t] && !fetch_dec[t] && occupancy[t*CNT_W +: CNT_W] == CNT_MAX
      |=> occupancy[t*CNT_W +: CNT_W] == CNT_MAX);
    p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_dec[t] && !fetch_inc[t] && occupancy[t*CNT_W +: CNT_W] == '0
      |=> occupancy[t*CNT_W +: CNT_W] == '0);
    p_grant_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
      grant[t] |-> thr_active[t] && !thr_stall[t]
      && occupancy[t*CNT_W +: CNT_W] < thr_cap[t*CNT_W +: CNT_W]);
    for (genvar j = 0; j < THREADS; j++) begin : g_cmp
      p_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant[t] && thr_active[j] && !thr_stall[j]
        && occupancy[j*CNT_W +: CNT_W] < thr_cap[j*CNT_W +: CNT_W]
        |-> occupancy[t*CNT_W +: CNT_W] <= occupancy[j*CNT_W +: CNT_W]);
    end
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    best  = '0;
    for (int k = 0; k < THREADS; k++) begin
      logic [PTR_W:0] wide;
      logic [PTR_W-1:0] idx;
      wide = {1'b0, rr_q} + (PTR_W+1)'(k);
      if (wide >= (PTR_W+1)'(THREADS)) wide = wide - (PTR_W+1)'(THREADS);
      idx = wide[PTR_W-1:0];
      if (elig[idx] && (!found || cnt_q[idx] < best)) begin
        found = 1'b1;
        best  = cnt_q[idx];
        pick  = idx;
      end
    end
  end

  assign grant = found ? (THREADS'(1) << pick) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) rr_q <= '0;
    else if (found) rr_q <= (pick == LAST) ? '0 : pick + 1'b1;
  end

  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  p_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(thr_active & ~thr_stall)) == 1'b0 |-> grant == '0);
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant == '0 |=> $stable(rr_q));
endmodule

// File: tb/occupancy_fetch_arbiter_bench.sv
module occupancy_fetch_arbiter_bench;
  localparam int N = 4;
  localparam int W = 3;
  localparam int MAXC = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] inc = '0, dec = '0, act = '0, stl = '0;
  logic [N*W-1:0] cap = '0;
  wire  [N-1:0] grant;
  wire  [N*W-1:0] occ;

  occupancy_fetch_arbiter #(.THREADS(N), .CNT_W(W)) u_occupancy_fetch_arbiter (
    .clk(clk), .rst_n(rst_n), .fetch_inc(inc), .fetch_dec(dec),
    .thr_active(act), .thr_stall(stl), .thr_cap(cap), .grant(grant), .occupancy(occ));

  always #5 clk = ~clk;

  int m_cnt [N];
  int m_cap [N];
  int m_ptr;
  int tests = 0, fails = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic chk(string req, string what, int actual, int expect_v);
    tests++;
    if (actual != expect_v) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expect_v);
    end
  endtask

  task automatic set_caps(int c0, int c1, int c2, int c3);
    m_cap[0] = c0; m_cap[1] = c1; m_cap[2] = c2; m_cap[3] = c3;
    for (int i = 0; i < N; i++) cap[i*W +: W] = W'(m_cap[i]);
  endtask

  function automatic int model_winner();
    int lo = 1000;
    for (int i = 0; i < N; i++)
      if (act[i] && !stl[i] && m_cnt[i] < m_cap[i] && m_cnt[i] < lo) lo = m_cnt[i];
    if (lo == 1000) return -1;
    for (int k = 0; k < N; k++) begin
      int t = (m_ptr + k) % N;
      if (act[t] && !stl[t] && m_cnt[t] < m_cap[t] && m_cnt[t] == lo) return t;
    end
    return -1;
  endfunction

  // Called just after a falling edge with inputs already driven.
  task automatic step(string req);
    int w;
    #1;
    w = model_winner();
    chk(req, "grant", int'(grant), (w < 0) ? 0 : (1 << w));
    for (int i = 0; i < N; i++) chk(req, "count", int'(occ[i*W +: W]), m_cnt[i]);
    for (int i = 0; i < N; i++) begin
      if (inc[i] && !dec[i] && m_cnt[i] < MAXC) m_cnt[i]++;
      else if (dec[i] && !inc[i] && m_cnt[i] > 0) m_cnt[i]--;
    end
    if (w >= 0) m_ptr = (w + 1) % N;
    @(negedge clk);
  endtask

  task automatic rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_cnt[i] = 0;
    m_ptr = 0;
    set_caps(7, 7, 7, 7);
    act = '1;
    inc = '1;
    @(negedge clk);
    @(negedge clk);
    #1;
    for (int i = 0; i < N; i++) chk("R1", "reset count", int'(occ[i*W +: W]), 0);
    @(negedge clk);
    rst_n = 1'b1;
    inc = '0;
    // R1 / R6 / R7: all counts tie, grant rotates from thread 0
    for (int c = 0; c < 6; c++) step("R6");
    // R9: lone active thread wins every cycle
    act = 4'b0100;
    for (int c = 0; c < 4; c++) step("R9");
    // R2: increments, simultaneous pulses, decrements
    act = '1;
    inc = 4'b0011; for (int c = 0; c < 3; c++) step("R2");
    inc = 4'b0011; dec = 4'b0011; step("R2"); step("R2");
    inc = '0; dec = 4'b0001; step("R2");
    // R3: saturate thread 3, floor thread 1
    dec = 4'b0010; inc = 4'b1000;
    for (int c = 0; c < 10; c++) step("R3");
    // R5: lowest count wins
    inc = '0; dec = '0;
    for (int c = 0; c < 4; c++) step("R5");
    // R4: caps and stalls exclude threads
    set_caps(0, 2, 7, 7);
    stl = 4'b0100;
    for (int c = 0; c < 4; c++) step("R4");
    // R8 / R7: nothing eligible, no grant, pointer held
    stl = '1;
    for (int c = 0; c < 3; c++) step("R8");
    act = '0; stl = '0;
    step("R8");
    act = '1;
    set_caps(7, 7, 7, 7);
    step("R7");
    // R5: pseudo-random sweep
    for (int c = 0; c < 4000; c++) begin
      rnd();
      inc = lfsr[3:0];
      dec = lfsr[7:4];
      act = (lfsr[11:8] == 4'b0) ? 4'b0001 : lfsr[11:8] | lfsr[15:12];
      stl = lfsr[19:16] & lfsr[23:20];
      if (c % 500 == 0) set_caps(int'(lfsr[26:24]), int'(lfsr[29:27]), 7, int'(lfsr[31:30]) + 4);
      step("R5");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule